// File: doc/BRIEF.md
# Non-binary radix search and digit decoder

This block applies digital correction to a residue converter whose stages resolve digits with a radix that is intentionally below two. Every code word holds twelve signed stage decisions in the set {-1, 0, +1}, one for each stage from the first to the last. The weight of stage n is the n-th negative power of the radix, so the radix has to be known before any code word can be turned into a value.

Calibration takes two captured code words, A and B, and steps a candidate radix from a lower bound to an upper bound by a fixed increment. For each candidate it builds the twelve weights and forms the weighted sum of the digit differences between A and B. It keeps the candidate whose sum has the smallest magnitude. This error is not monotonic in the radix, because redundant digit patterns can land close to the same value. For that reason the block sweeps the whole range and does not follow a slope. The winner becomes the stored radix and its weights stay in a twelve-entry coefficient file.

Conversion runs one digit per cycle through a multiply-accumulate over the stored weights. It returns a signed fixed-point result on a valid strobe after a fixed latency. Out of reset the stored radix is 2.0, so an uncalibrated block decodes plain binary-weighted digits.

Top module: `bx_radix_decoder`

## Requirements
- R1: Stage n (n = 1..12) occupies bits [2n-1:2n-2] of a code word. The encoding is 2'b01 = +1 and 2'b11 = -1. Both 2'b00 and the unused pattern 2'b10 count as 0 and contribute nothing.
- R2: A conversion result is the exact sum of d_n * c_n over all twelve stages. It is a signed 21-bit value with 15 fraction bits, and no rounding is applied during accumulation.
- R3: The radix is an unsigned 17-bit value with 15 fraction bits (1.0 = 0x08000, 2.0 = 0x10000). Only the range 1.0 to 2.0 is supported. The weights are built as follows:
  - r = floor(2^30 / radix)
  - c_1 = r
  - c_n = floor(c_(n-1) * r / 2^15)
- R4: A code word is accepted on a cycle where in_valid and in_ready are both high. Exactly 13 clock edges later, out_valid is high for one cycle with the result. Between acceptance and that edge, in_ready stays low and out_valid stays low.
- R5: After reset the following hold:
  - The radix reads 0x10000 and the weights equal 2^(15-n), so decoding is binary.
  - in_ready is high.
  - out_valid and cal_done are low.
- R6: cal_start is acted on only in a cycle where in_ready is high and in_valid is low. From then until cal_done, in_ready is low, and no code word offered on the input is accepted or produces a result.
- R7: The sweep works as follows:
  - The candidates are lo, lo+step, lo+2*step and so on, while the candidate does not exceed hi. A step of 0 tries lo alone.
  - For each candidate the error is sum (dA_n - dB_n) * c_n.
  - The candidate with the smallest absolute error wins, and on a tie the earliest candidate wins.
- R8: When cal_done rises, beta_o shows the winning radix and the coefficient file holds that radix's weights, so all later conversions use it. beta_o changes in no other cycle.
- R9: cal_done is a one-cycle pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Code word offered |
| in_ready | output | 1 | Block can take a code word |
| in_code | input | 24 | Twelve 2-bit stage digits |
| out_valid | output | 1 | Result strobe |
| out_result | output | 21 | Signed result, 15 fraction bits |
| cal_start | input | 1 | Begin a radix sweep |
| cal_code_a | input | 24 | First captured code word |
| cal_code_b | input | 24 | Second captured code word |
| sweep_lo | input | 17 | First candidate radix |
| sweep_hi | input | 17 | Largest candidate radix |
| sweep_step | input | 17 | Candidate increment |
| cal_done | output | 1 | Sweep finished, radix updated |
| beta_o | output | 17 | Stored radix |

## Verification
Before calibration, the decoder is driven with the following patterns:
- All-zero, all-plus and all-minus words.
- A lone digit at the first stage and a lone digit at the last stage. These prove the bit ordering and the sign of each digit.
- A word made only of the unused pattern. This proves the unused pattern is treated as zero.
- Alternating-sign words. These catch a swapped or misweighted stage.

Sweeps are run on digit pairs whose zero crossing lies near the golden ratio and near the tribonacci constant. Each check requires the exact winning candidate, which separates a correct weight chain and a strict-minimum comparison from near misses. A pair of identical words must return the lower bound, which shows that ties keep the first candidate. A zero step must also return the lower bound, which shows the sweep stops at one candidate. Conversions after calibration then show that the reloaded weights, and not the reset weights, are in use.

// File: rtl/bx_pkg.sv
package bx_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CONV,
        ST_CAL_COEF,
        ST_CAL_ACC,
        ST_CAL_FIN
    } ctl_state_e;

    localparam logic [1:0] DIG_POS = 2'b01;
    localparam logic [1:0] DIG_NEG = 2'b11;

    // Map a 2-bit stage decision onto a signed value; unused pattern reads as zero.
    function automatic logic [1:0] digit_value(input logic [1:0] raw);
        case (raw)
            DIG_POS: return 2'b01;
            DIG_NEG: return 2'b11;
            default: return 2'b00;
        endcase
    endfunction

endpackage

// File: rtl/bx_recip.sv
// Iterative restoring divider: quot = floor(2^(2*FRAC) / divisor), one bit per cycle.
module bx_recip #(
    parameter int FRAC = 15,
    localparam int BETA_W = FRAC + 2,
    localparam int QUOT_W = FRAC + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [BETA_W-1:0] divisor,
    output logic              done,
    output logic [QUOT_W-1:0] quot
);

    localparam int WIDE_W = 2 * FRAC + 2;
    localparam int IDX_W  = $clog2(QUOT_W);

    typedef struct packed {
        logic              busy;
        logic              done;
        logic [IDX_W-1:0]  idx;
        logic [BETA_W-1:0] dvsr;
        logic [WIDE_W-1:0] rem;
        logic [QUOT_W-1:0] quot;
    } div_state_t;

    div_state_t div_d, div_q;
    logic [WIDE_W-1:0] shifted;

    always_comb begin
        div_d      = div_q;
        div_d.done = 1'b0;
        shifted    = WIDE_W'(div_q.dvsr) << div_q.idx;
        if (start) begin
            div_d.busy = 1'b1;
            div_d.dvsr = divisor;
            div_d.rem  = WIDE_W'(1) << (2 * FRAC);
            div_d.quot = '0;
            div_d.idx  = IDX_W'(QUOT_W - 1);
        end else if (div_q.busy) begin
            if (div_q.rem >= shifted) begin
                div_d.rem             = div_q.rem - shifted;
                div_d.quot[div_q.idx] = 1'b1;
            end
            if (div_q.idx == '0) begin
                div_d.busy = 1'b0;
                div_d.done = 1'b1;
            end else begin
                div_d.idx = div_q.idx - IDX_W'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            div_q <= '0;
        end else begin
            div_q <= div_d;
        end
    end

    assign done = div_q.done;
    assign quot = div_q.quot;

endmodule

// File: rtl/bx_coef_gen.sv
// Builds the negative radix powers: reciprocal first, then one product per cycle.
module bx_coef_gen #(
    parameter int NDIG = 12,
    parameter int FRAC = 15,
    localparam int BETA_W = FRAC + 2,
    localparam int COEF_W = FRAC + 1
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         start,
    input  logic [BETA_W-1:0]            beta,
    output logic                         done,
    output logic [NDIG-1:0][COEF_W-1:0]  coef
);

    localparam int N_W  = $clog2(NDIG);
    localparam int PR_W = 2 * COEF_W;

    typedef logic [NDIG-1:0][COEF_W-1:0] coef_arr_t;

    function automatic coef_arr_t binary_coefs();
        coef_arr_t r;
        for (int k = 0; k < NDIG; k++) begin
            r[k] = COEF_W'(1) << (FRAC - 1 - k);
        end
        return r;
    endfunction

    localparam coef_arr_t RST_COEF = binary_coefs();

    typedef struct packed {
        logic           pow_busy;
        logic           done;
        logic [N_W-1:0] n;
        coef_arr_t      coef;
    } gen_state_t;

    gen_state_t gen_d, gen_q;
    logic              rc_done;
    logic [COEF_W-1:0] rc_quot;
    logic [N_W-1:0]    prev_idx;
    logic [PR_W-1:0]   prod;

    bx_recip #(.FRAC(FRAC)) u_recip (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (start),
        .divisor (beta),
        .done    (rc_done),
        .quot    (rc_quot)
    );

    always_comb begin
        gen_d      = gen_q;
        gen_d.done = 1'b0;
        prev_idx   = gen_q.n - N_W'(1);
        prod       = PR_W'(gen_q.coef[prev_idx]) * PR_W'(gen_q.coef[0]);
        if (rc_done) begin
            gen_d.coef[0]  = rc_quot;
            gen_d.n        = N_W'(1);
            gen_d.pow_busy = 1'b1;
        end else if (gen_q.pow_busy) begin
            gen_d.coef[gen_q.n] = COEF_W'(prod >> FRAC);
            if (gen_q.n == N_W'(NDIG - 1)) begin
                gen_d.pow_busy = 1'b0;
                gen_d.done     = 1'b1;
            end else begin
                gen_d.n = gen_q.n + N_W'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gen_q.pow_busy <= 1'b0;
            gen_q.done     <= 1'b0;
            gen_q.n        <= '0;
            gen_q.coef     <= RST_COEF;
        end else begin
            gen_q <= gen_d;
        end
    end

    assign done = gen_q.done;
    assign coef = gen_q.coef;

endmodule

// File: rtl/bx_mac.sv
// Serial multiply-accumulate of signed digits against the coefficient file.
module bx_mac #(
    parameter int NDIG  = 12,
    parameter int FRAC  = 15,
    parameter int ACC_W = 21,
    localparam int COEF_W = FRAC + 1
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        start,
    input  logic [NDIG-1:0][2:0]        digits,
    input  logic [NDIG-1:0][COEF_W-1:0] coef,
    output logic                        done,
    output logic signed [ACC_W-1:0]     sum
);

    localparam int N_W = $clog2(NDIG);

    typedef struct packed {
        logic                    busy;
        logic                    done;
        logic [N_W-1:0]          idx;
        logic signed [ACC_W-1:0] acc;
    } mac_state_t;

    mac_state_t mac_d, mac_q;
    logic [2:0]              cur_dig;
    logic signed [ACC_W-1:0] term;

    always_comb begin
        mac_d      = mac_q;
        mac_d.done = 1'b0;
        cur_dig    = digits[mac_q.idx];
        term       = $signed({{(ACC_W - 3){cur_dig[2]}}, cur_dig})
                   * $signed({{(ACC_W - COEF_W){1'b0}}, coef[mac_q.idx]});
        if (start) begin
            mac_d.busy = 1'b1;
            mac_d.idx  = '0;
            mac_d.acc  = '0;
        end else if (mac_q.busy) begin
            mac_d.acc = mac_q.acc + term;
            if (mac_q.idx == N_W'(NDIG - 1)) begin
                mac_d.busy = 1'b0;
                mac_d.done = 1'b1;
            end else begin
                mac_d.idx = mac_q.idx + N_W'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mac_q <= '0;
        end else begin
            mac_q <= mac_d;
        end
    end

    assign done = mac_q.done;
    assign sum  = mac_q.acc;

endmodule

// File: rtl/bx_radix_decoder.sv
module bx_radix_decoder
    import bx_pkg::*;
#(
    parameter int NDIG = 12,
    parameter int FRAC = 15,
    localparam int CODE_W = 2 * NDIG,
    localparam int BETA_W = FRAC + 2,
    localparam int ACC_W  = FRAC + $clog2(2 * NDIG) + 1
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     in_valid,
    output logic                     in_ready,
    input  logic [CODE_W-1:0]        in_code,
    output logic                     out_valid,
    output logic signed [ACC_W-1:0]  out_result,
    input  logic                     cal_start,
    input  logic [CODE_W-1:0]        cal_code_a,
    input  logic [CODE_W-1:0]        cal_code_b,
    input  logic [BETA_W-1:0]        sweep_lo,
    input  logic [BETA_W-1:0]        sweep_hi,
    input  logic [BETA_W-1:0]        sweep_step,
    output logic                     cal_done,
    output logic [BETA_W-1:0]        beta_o
);

    localparam int COEF_W = FRAC + 1;

    typedef struct packed {
        ctl_state_e              state;
        logic [CODE_W-1:0]       code_a;
        logic [CODE_W-1:0]       code_b;
        logic [BETA_W-1:0]       hi;
        logic [BETA_W-1:0]       step;
        logic [BETA_W-1:0]       cand;
        logic [BETA_W-1:0]       best;
        logic [ACC_W-1:0]        best_mag;
        logic [BETA_W-1:0]       beta;
        logic signed [ACC_W-1:0] res;
        logic                    out_valid;
        logic                    cal_done;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic                        coef_start;
    logic [BETA_W-1:0]           coef_beta;
    logic                        coef_done;
    logic [NDIG-1:0][COEF_W-1:0] coef;
    logic                        mac_start;
    logic [NDIG-1:0][2:0]        mac_digits;
    logic                        mac_done;
    logic signed [ACC_W-1:0]     mac_sum;
    logic [ACC_W-1:0]            mag;
    logic [BETA_W:0]             next_cand;
    logic [BETA_W-1:0]           winner;
    logic                        accept;

    bx_coef_gen #(.NDIG(NDIG), .FRAC(FRAC)) u_coef (
        .clk   (clk),
        .rst_n (rst_n),
        .start (coef_start),
        .beta  (coef_beta),
        .done  (coef_done),
        .coef  (coef)
    );

    bx_mac #(.NDIG(NDIG), .FRAC(FRAC), .ACC_W(ACC_W)) u_mac (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (mac_start),
        .digits (mac_digits),
        .coef   (coef),
        .done   (mac_done),
        .sum    (mac_sum)
    );

    // Digit differences A - B; conversion clears B so the same path decodes one word.
    always_comb begin
        for (int k = 0; k < NDIG; k++) begin
            logic [1:0] dva;
            logic [1:0] dvb;
            dva           = digit_value(ctl_q.code_a[2*k +: 2]);
            dvb           = digit_value(ctl_q.code_b[2*k +: 2]);
            mac_digits[k] = {dva[1], dva} - {dvb[1], dvb};
        end
    end

    assign in_ready  = (ctl_q.state == ST_IDLE);
    assign accept    = in_valid && in_ready;
    assign mag       = mac_sum[ACC_W-1] ? $unsigned(-mac_sum) : $unsigned(mac_sum);
    assign next_cand = {1'b0, ctl_q.cand} + {1'b0, ctl_q.step};
    assign winner    = (mag < ctl_q.best_mag) ? ctl_q.cand : ctl_q.best;

    always_comb begin
        ctl_d           = ctl_q;
        ctl_d.out_valid = 1'b0;
        ctl_d.cal_done  = 1'b0;
        coef_start      = 1'b0;
        coef_beta       = ctl_q.cand;
        mac_start       = 1'b0;
        case (ctl_q.state)
            ST_IDLE: begin
                if (accept) begin
                    ctl_d.code_a = in_code;
                    ctl_d.code_b = '0;
                    mac_start    = 1'b1;
                    ctl_d.state  = ST_CONV;
                end else if (cal_start) begin
                    ctl_d.code_a   = cal_code_a;
                    ctl_d.code_b   = cal_code_b;
                    ctl_d.hi       = sweep_hi;
                    ctl_d.step     = sweep_step;
                    ctl_d.cand     = sweep_lo;
                    ctl_d.best     = sweep_lo;
                    ctl_d.best_mag = '1;
                    coef_start     = 1'b1;
                    coef_beta      = sweep_lo;
                    ctl_d.state    = ST_CAL_COEF;
                end
            end
            ST_CONV: begin
                if (mac_done) begin
                    ctl_d.res       = mac_sum;
                    ctl_d.out_valid = 1'b1;
                    ctl_d.state     = ST_IDLE;
                end
            end
            ST_CAL_COEF: begin
                if (coef_done) begin
                    mac_start   = 1'b1;
                    ctl_d.state = ST_CAL_ACC;
                end
            end
            ST_CAL_ACC: begin
                if (mac_done) begin
                    if (mag < ctl_q.best_mag) begin
                        ctl_d.best_mag = mag;
                        ctl_d.best     = ctl_q.cand;
                    end
                    coef_start = 1'b1;
                    if ((ctl_q.step == '0) || (next_cand > {1'b0, ctl_q.hi})) begin
                        coef_beta   = winner;
                        ctl_d.state = ST_CAL_FIN;
                    end else begin
                        ctl_d.cand  = next_cand[BETA_W-1:0];
                        coef_beta   = next_cand[BETA_W-1:0];
                        ctl_d.state = ST_CAL_COEF;
                    end
                end
            end
            ST_CAL_FIN: begin
                if (coef_done) begin
                    ctl_d.beta     = ctl_q.best;
                    ctl_d.cal_done = 1'b1;
                    ctl_d.state    = ST_IDLE;
                end
            end
            default: ctl_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q          <= '0;
            ctl_q.state    <= ST_IDLE;
            ctl_q.best_mag <= '1;
            ctl_q.beta     <= BETA_W'(1) << (FRAC + 1);
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign out_valid  = ctl_q.out_valid;
    assign out_result = ctl_q.res;
    assign cal_done   = ctl_q.cal_done;
    assign beta_o     = ctl_q.beta;

endmodule

// File: rtl/bx_radix_decoder_chk.sv
module bx_radix_decoder_chk #(
    parameter int NDIG   = 12,
    parameter int BETA_W = 17
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic              in_ready,
    input logic              out_valid,
    input logic              cal_start,
    input logic              cal_done,
    input logic [BETA_W-1:0] beta_o
);

    localparam int LAT   = NDIG + 2;
    localparam int CNT_W = $clog2(LAT + 1);

    logic [CNT_W-1:0] lat_cnt;
    logic             cal_act;

    // Cycles since the last accepted code word, tracked from the ports only.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lat_cnt <= '0;
        end else if (in_valid && in_ready) begin
            lat_cnt <= CNT_W'(1);
        end else if (lat_cnt != '0 && lat_cnt != CNT_W'(LAT)) begin
            lat_cnt <= lat_cnt + CNT_W'(1);
        end else begin
            lat_cnt <= '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cal_act <= 1'b0;
        end else if (cal_done) begin
            cal_act <= 1'b0;
        end else if (cal_start && in_ready && !in_valid) begin
            cal_act <= 1'b1;
        end
    end

    assert_result_latency_R4: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid == (lat_cnt == CNT_W'(LAT)));

    assert_result_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |=> !out_valid);

    assert_ready_low_in_cal_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (cal_act && !cal_done) |-> !in_ready);

    assert_done_only_in_cal_R6: assert property (@(posedge clk) disable iff (!rst_n)
        cal_done |-> cal_act);

    assert_beta_moves_at_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(beta_o) |-> cal_done);

    assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        cal_done |=> !cal_done);

endmodule

bind bx_radix_decoder bx_radix_decoder_chk #(.NDIG(NDIG), .BETA_W(BETA_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .out_valid (out_valid),
    .cal_start (cal_start),
    .cal_done  (cal_done),
    .beta_o    (beta_o)
);

// File: tb/bx_radix_decoder_test.sv
module bx_radix_decoder_test;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               in_valid = 1'b0;
    logic               in_ready;
    logic [23:0]        in_code = '0;
    logic               out_valid;
    logic signed [20:0] out_result;
    logic               cal_start = 1'b0;
    logic [23:0]        cal_code_a = '0;
    logic [23:0]        cal_code_b = '0;
    logic [16:0]        sweep_lo = '0;
    logic [16:0]        sweep_hi = '0;
    logic [16:0]        sweep_step = '0;
    logic               cal_done;
    logic [16:0]        beta_o;

    int checks = 0;
    int failures = 0;

    always #4 clk = ~clk;

    bx_radix_decoder uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_valid   (in_valid),
        .in_ready   (in_ready),
        .in_code    (in_code),
        .out_valid  (out_valid),
        .out_result (out_result),
        .cal_start  (cal_start),
        .cal_code_a (cal_code_a),
        .cal_code_b (cal_code_b),
        .sweep_lo   (sweep_lo),
        .sweep_hi   (sweep_hi),
        .sweep_step (sweep_step),
        .cal_done   (cal_done),
        .beta_o     (beta_o)
    );

    typedef struct packed {
        logic [23:0]        code;
        logic signed [20:0] exp;
    } vec_t;

    // Binary weights out of reset: stage n weighs 2^(15-n).
    localparam vec_t VECS [0:7] = '{
        '{24'h000000,  21'sd0},
        '{24'h555555,  21'sd32760},
        '{24'hFFFFFF, -21'sd32760},
        '{24'h000001,  21'sd16384},
        '{24'hC00000, -21'sd8},
        '{24'hAAAAAA,  21'sd0},
        '{24'h00000D,  21'sd8192},
        '{24'hDDDDDD,  21'sd10920}
    };

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic longint m_dig(input logic [1:0] raw);
        if (raw == 2'b01) return 1;
        if (raw == 2'b11) return -1;
        return 0;
    endfunction

    // Weighted digit difference per R3 weights and R2 exact accumulation.
    function automatic longint m_sum(input logic [23:0] a, input logic [23:0] b,
                                     input longint beta);
        longint r;
        longint c;
        longint s;
        r = (longint'(1) << 30) / beta;
        c = r;
        s = 0;
        for (int n = 0; n < 12; n++) begin
            if (n > 0) c = (c * r) >> 15;
            s += (m_dig(a[2*n +: 2]) - m_dig(b[2*n +: 2])) * c;
        end
        return s;
    endfunction

    function automatic longint m_best(input logic [23:0] a, input logic [23:0] b,
                                      input longint lo, input longint hi, input longint step);
        longint cand;
        longint best;
        longint best_mag;
        longint e;
        cand = lo;
        best = lo;
        best_mag = 64'h7fffffffffffffff;
        forever begin
            e = m_sum(a, b, cand);
            if (e < 0) e = -e;
            if (e < best_mag) begin
                best_mag = e;
                best = cand;
            end
            if (step == 0 || cand + step > hi) break;
            cand += step;
        end
        return best;
    endfunction

    task automatic run_conv(input logic [23:0] code, input longint exp, input string req);
        bit quiet;
        while (!in_ready) @(negedge clk);
        in_valid = 1'b1;
        in_code  = code;
        @(posedge clk);
        @(negedge clk);
        in_valid = 1'b0;
        quiet = 1'b1;
        repeat (12) begin
            @(negedge clk);
            if (out_valid || in_ready) quiet = 1'b0;
        end
        check(quiet, "R4", "busy window out_valid|in_ready", longint'(quiet), 1);
        @(negedge clk);
        check(out_valid == 1'b1, "R4", "out_valid 13 edges after accept", out_valid, 1);
        check(longint'(out_result) == exp, req, $sformatf("result code %h", code),
              longint'(out_result), exp);
        @(negedge clk);
        check(out_valid == 1'b0, "R4", "out_valid one cycle", out_valid, 0);
    endtask

    task automatic run_cal(input logic [23:0] a, input logic [23:0] b,
                           input logic [16:0] lo, input logic [16:0] hi,
                           input logic [16:0] step, input string what);
        longint exp;
        bit     ready_seen;
        bit     out_seen;
        bit     done_seen;
        exp = m_best(a, b, longint'(lo), longint'(hi), longint'(step));
        while (!in_ready) @(negedge clk);
        cal_code_a = a;
        cal_code_b = b;
        sweep_lo   = lo;
        sweep_hi   = hi;
        sweep_step = step;
        cal_start  = 1'b1;
        @(posedge clk);
        @(negedge clk);
        cal_start = 1'b0;
        in_valid  = 1'b1;
        in_code   = 24'h555555;
        ready_seen = 1'b0;
        out_seen   = 1'b0;
        done_seen  = 1'b0;
        for (int i = 0; i < 60000; i++) begin
            if (i == 20) in_valid = 1'b0;
            if (cal_done) begin
                done_seen = 1'b1;
                break;
            end
            if (in_ready) ready_seen = 1'b1;
            if (out_valid) out_seen = 1'b1;
            @(negedge clk);
        end
        in_valid = 1'b0;
        check(done_seen, "R9", {what, " cal_done raised"}, longint'(done_seen), 1);
        check(!ready_seen, "R6", {what, " in_ready low in sweep"}, longint'(ready_seen), 0);
        check(!out_seen, "R6", {what, " no result in sweep"}, longint'(out_seen), 0);
        check(longint'(beta_o) == exp, "R7", {what, " winning radix"}, longint'(beta_o), exp);
        @(negedge clk);
        check(cal_done == 1'b0, "R9", {what, " cal_done one cycle"}, cal_done, 0);
    endtask

    initial begin : watchdog
        repeat (190000) @(posedge clk);
        failures++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin : main
        longint b_gold;
        longint b_trib;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R5: state after reset
        check(in_ready == 1'b1, "R5", "in_ready after reset", in_ready, 1);
        check(out_valid == 1'b0, "R5", "out_valid after reset", out_valid, 0);
        check(cal_done == 1'b0, "R5", "cal_done after reset", cal_done, 0);
        check(beta_o == 17'h10000, "R5", "radix after reset", beta_o, 17'h10000);

        // R1, R2: binary decoding with reset weights
        for (int v = 0; v < 8; v++) begin
            run_conv(VECS[v].code, longint'(VECS[v].exp), "R1/R2 binary decode");
        end

        // R7, R8: sweep near the golden ratio (digit 1 against digits 2 and 3)
        b_gold = m_best(24'h000001, 24'h000014, 64'hC000, 64'hE000, 64'h40);
        run_cal(24'h000001, 24'h000014, 17'h0C000, 17'h0E000, 17'h00040, "golden");
        run_conv(24'h555555, m_sum(24'h555555, 24'h0, b_gold), "R8 decode after sweep");
        run_conv(24'hDDDDDD, m_sum(24'hDDDDDD, 24'h0, b_gold), "R3 weights after sweep");

        // R7: sweep near the tribonacci constant
        b_trib = m_best(24'h000001, 24'h000054, 64'hE000, 64'hFA00, 64'h80);
        run_cal(24'h000001, 24'h000054, 17'h0E000, 17'h0FA00, 17'h00080, "tribonacci");
        run_conv(24'hC00001, m_sum(24'hC00001, 24'h0, b_trib), "R3 last stage weight");

        // R7: identical words tie everywhere, earliest candidate kept
        run_cal(24'h123456, 24'h123456, 17'h0C800, 17'h0F000, 17'h00400, "tie");
        check(beta_o == 17'h0C800, "R7", "tie keeps lower bound", beta_o, 17'h0C800);

        // R7: zero step tries the lower bound only
        run_cal(24'h000001, 24'h000014, 17'h0D000, 17'h0F000, 17'h00000, "zero step");
        check(beta_o == 17'h0D000, "R7", "zero step result", beta_o, 17'h0D000);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule